// File: doc/BRIEF.md
# LIN Identifier Filter and Interrupt Router

This block sits beside a LIN frame receiver. Each time the receiver has taken in a protected identifier, it presents the 6-bit identifier with a one-cycle valid strobe. The block compares it against a bank of sixteen programmable filter slots. It then decides whether the frame raises a transmit interrupt, a receive interrupt, or nothing. When a slot matches, the block also reports which slot won, along with that slot's data length code and checksum type. The receiver uses these to size and check the response field.

The slots are grouped in pairs (2n, 2n+1). Each pair has a mode bit. With the bit clear, the two slots are independent exact-match identifiers. With the bit set, slot 2n holds the identifier and slot 2n+1 holds a bit mask, and the pair acts as one wildcard filter. Software sets up slots, activation bits and pair modes through a simple write port.

Top module: `lin_id_filter`

## Requirements
- R1: While reset is asserted, and after it is released until the first identifier strobe, `tx_irq`, `rx_irq` and `hit_vld` are 0, and `hit_idx`, `hit_len` and `hit_chk` are 0.
- R2: When no slot is active, every identifier gives `rx_irq` with `hit_vld` = 0.
- R3: In list mode, an identifier equal to the key of an active slot whose direction bit is 1 (TX) gives `tx_irq` and `hit_vld`, with `hit_idx` set to that slot and `hit_len`/`hit_chk` set to its fields.
- R4: An identifier equal to the key of an active slot whose direction bit is 0 (RX) gives `rx_irq` and `hit_vld` with that slot's index, length and checksum type.
- R5: With pair mode bit n = 1, slot 2n matches when every identifier bit at a 1 in slot 2n+1's key field equals slot 2n's key bit, and other bits are don't-care. The pair then uses slot 2n's activation, direction, length and checksum, and reports index 2n. Slot 2n+1 never matches by itself.
- R6: When no active slot has RX direction, an identifier that matches nothing gives `rx_irq` with `hit_vld` = 0.
- R7: When at least one active RX slot exists, an identifier that matches nothing gives no interrupt.
- R8: When several slots match, the lowest index wins and alone decides the interrupt and match fields.
- R9: A slot whose activation bit is 0 is ignored both for matching and for the RX-slot count.
- R10: Results appear on the clock edge that samples `id_vld` and last exactly one cycle. At most one of `tx_irq`/`rx_irq` is set. All result outputs are 0 in any cycle that follows a cycle without a strobe.
- R11: Write map. Addresses 0–15 write slot registers:
  - bits [5:0]: key (identifier or mask)
  - bit 6: direction, 1 = TX
  - bits [9:7]: length code, code+1 data bytes
  - bit 10: checksum type, 1 = enhanced

  Address 16 writes activation bits [15:0], one bit per slot. Address 17 writes pair mode bits [7:0]. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| id_vld | input | 1 | Identifier valid strobe |
| id | input | 6 | Received identifier |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| hit_vld | output | 1 | A slot matched |
| hit_idx | output | 4 | Index of the winning slot |
| hit_len | output | 3 | Length code of the winning slot |
| hit_chk | output | 1 | Checksum type of the winning slot |

## Verification
Every result is due one clock after the strobe is sampled. The decision register is the only stage, so the bench raises `id_vld` at a falling edge and lowers it at the next falling edge. It reads all six result outputs at that second falling edge. A configuration write becomes visible to the first strobe sampled after the write edge, so writes finish one full cycle before any strobe that depends on them. One more falling-edge sample after each strobe confirms that the outputs have returned to 0.

// File: rtl/lin_flt_pkg.sv
// Shared constants and the slot register layout for the LIN identifier filter.
// Assumes the slot count is even so slots form whole pairs.
package lin_flt_pkg;
    localparam int ID_W      = 6;
    localparam int LEN_W     = 3;
    localparam int NUM_FLT   = 16;
    localparam int NUM_PAIR  = NUM_FLT / 2;
    localparam int IDX_W     = $clog2(NUM_FLT);
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int ADDR_ACT  = NUM_FLT;
    localparam int ADDR_MODE = NUM_FLT + 1;

    // One slot register; first member is the most significant field.
    typedef struct packed {
        logic             chk;   // 1 = enhanced checksum
        logic [LEN_W-1:0] len;   // data bytes minus one
        logic             dir;   // 1 = TX, 0 = RX
        logic [ID_W-1:0]  key;   // identifier or mask
    } flt_cfg_t;

    localparam int CFG_BITS = $bits(flt_cfg_t);
endpackage

// File: rtl/lin_flt_regs.sv
// Configuration storage: slot registers, activation bits and pair mode bits.
// Assumes one write per cycle; unmapped addresses are dropped.
module lin_flt_regs
    import lin_flt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output flt_cfg_t            cfg [NUM_FLT],
    output logic [NUM_FLT-1:0]  act,
    output logic [NUM_PAIR-1:0] pair_mask_mode
);
    // Holds slot registers and control bits, updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_FLT; i++) cfg[i] <= '0;
            act            <= '0;
            pair_mask_mode <= '0;
        end else if (cfg_we) begin
            if (cfg_addr < ADDR_W'(NUM_FLT))
                cfg[cfg_addr[IDX_W-1:0]] <= flt_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
            else if (cfg_addr == ADDR_W'(ADDR_ACT))
                act <= cfg_wdata[NUM_FLT-1:0];
            else if (cfg_addr == ADDR_W'(ADDR_MODE))
                pair_mask_mode <= cfg_wdata[NUM_PAIR-1:0];
        end
    end
endmodule

// File: rtl/lin_flt_pair.sv
// Match logic for one slot pair, in list mode (two exact keys) or
// mask mode (key in the even slot, mask in the odd slot). Purely combinational.
module lin_flt_pair
    import lin_flt_pkg::*;
(
    input  logic [ID_W-1:0] id,
    input  flt_cfg_t        cfg_lo,
    input  flt_cfg_t        cfg_hi,
    input  logic            act_lo,
    input  logic            act_hi,
    input  logic            mask_mode,
    output logic [1:0]      hit,
    output logic [1:0]      eff_act
);
    logic [ID_W-1:0] diff_lo;
    logic [ID_W-1:0] diff_hi;

    // Bitwise differences between the identifier and each key.
    assign diff_lo = id ^ cfg_lo.key;
    assign diff_hi = id ^ cfg_hi.key;

    // Selects exact or masked comparison and the slots that count as active.
    always_comb begin
        if (mask_mode) begin
            eff_act = {1'b0, act_lo};
            hit     = {1'b0, act_lo && ((diff_lo & cfg_hi.key) == '0)};
        end else begin
            eff_act = {act_hi, act_lo};
            hit     = {act_hi && (diff_hi == '0), act_lo && (diff_lo == '0)};
        end
    end
endmodule

// File: rtl/lin_flt_route.sv
// Picks the lowest matching slot and decides TX, RX or no interrupt.
// Registers the decision so results appear one clock after the strobe.
module lin_flt_route
    import lin_flt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_vld,
    input  logic [NUM_FLT-1:0] hit,
    input  logic [NUM_FLT-1:0] eff_act,
    input  flt_cfg_t           cfg [NUM_FLT],
    output logic               tx_irq,
    output logic               rx_irq,
    output logic               hit_vld,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [LEN_W-1:0]   hit_len,
    output logic               hit_chk
);
    logic [NUM_FLT-1:0] dir_vec;
    logic               any_rx;
    logic               found;
    logic [IDX_W-1:0]   sel;
    logic               tx_n, rx_n;

    // Collects the direction bits of all slots.
    always_comb begin
        for (int i = 0; i < NUM_FLT; i++) dir_vec[i] = cfg[i].dir;
    end

    assign any_rx = |(eff_act & ~dir_vec);

    // Lowest-index priority encoder over the hit vector.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_FLT; i++) begin
            if (!found && hit[i]) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    // Interrupt routing from the winner or from the RX-slot count.
    always_comb begin
        tx_n = id_vld && found && cfg[sel].dir;
        rx_n = id_vld && (found ? !cfg[sel].dir : !any_rx);
    end

    // Decision register; outputs clear when no strobe is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq  <= 1'b0;
            rx_irq  <= 1'b0;
            hit_vld <= 1'b0;
            hit_idx <= '0;
            hit_len <= '0;
            hit_chk <= 1'b0;
        end else begin
            tx_irq  <= tx_n;
            rx_irq  <= rx_n;
            hit_vld <= id_vld && found;
            hit_idx <= (id_vld && found) ? sel : '0;
            hit_len <= (id_vld && found) ? cfg[sel].len : '0;
            hit_chk <= id_vld && found && cfg[sel].chk;
        end
    end
endmodule

// File: rtl/lin_id_filter.sv
// Top: LIN identifier filter bank with interrupt routing.
// Assumes id is stable whenever id_vld is high; config writes take effect
// for strobes sampled on later edges.
module lin_id_filter
    import lin_flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              id_vld,
    input  logic [5:0]        id,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              hit_vld,
    output logic [3:0]        hit_idx,
    output logic [2:0]        hit_len,
    output logic              hit_chk
);
    flt_cfg_t            cfg [NUM_FLT];
    logic [NUM_FLT-1:0]  act;
    logic [NUM_PAIR-1:0] pair_mask_mode;
    logic [NUM_FLT-1:0]  hit;
    logic [NUM_FLT-1:0]  eff_act;

    lin_flt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg(cfg), .act(act), .pair_mask_mode(pair_mask_mode)
    );

    // One match unit per slot pair.
    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        lin_flt_pair u_pair (
            .id(id), .cfg_lo(cfg[2*p]), .cfg_hi(cfg[2*p+1]),
            .act_lo(act[2*p]), .act_hi(act[2*p+1]),
            .mask_mode(pair_mask_mode[p]),
            .hit(hit[2*p+1:2*p]), .eff_act(eff_act[2*p+1:2*p])
        );
    end

    lin_flt_route u_route (
        .clk(clk), .rst_n(rst_n), .id_vld(id_vld), .hit(hit), .eff_act(eff_act),
        .cfg(cfg), .tx_irq(tx_irq), .rx_irq(rx_irq), .hit_vld(hit_vld),
        .hit_idx(hit_idx), .hit_len(hit_len), .hit_chk(hit_chk)
    );
endmodule

// File: rtl/lin_id_filter_chk.sv
// Temporal checks on the filter's result outputs, bound to the top module.
module lin_id_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       id_vld,
    input logic       tx_irq,
    input logic       rx_irq,
    input logic       hit_vld,
    input logic [3:0] hit_idx
);
    // R10
    no_dual_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_irq && rx_irq));

    // R10
    irq_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_vld |=> !(tx_irq || rx_irq || hit_vld));

    // R3
    tx_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> hit_vld);

    // R4
    hit_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |-> (tx_irq || rx_irq));

    // R1
    idx_zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vld |-> (hit_idx == 4'd0));
endmodule

bind lin_id_filter lin_id_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .id_vld(id_vld), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .hit_vld(hit_vld), .hit_idx(hit_idx)
);

// File: tb/sim_lin_id_filter.sv
module sim_lin_id_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        id_vld = 1'b0;
    logic [5:0]  id = '0;
    logic        tx_irq, rx_irq, hit_vld, hit_chk;
    logic [3:0]  hit_idx;
    logic [2:0]  hit_len;

    int n_chk = 0;
    int n_fail = 0;

    logic [10:0] sh_cfg [16];
    logic [15:0] sh_act;
    logic [7:0]  sh_mode;

    always #4 clk = ~clk;

    lin_id_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .id_vld(id_vld), .id(id), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .hit_vld(hit_vld), .hit_idx(hit_idx),
        .hit_len(hit_len), .hit_chk(hit_chk)
    );

    // Result vector {tx, rx, hit_vld, idx[3:0], len[2:0], chk}.
    function automatic logic [10:0] outs();
        return {tx_irq, rx_irq, hit_vld, hit_idx, hit_len, hit_chk};
    endfunction

    function automatic logic [10:0] model(input logic [5:0] v);
        logic [15:0] hit, eff;
        logic        any_rx;
        hit = '0; eff = '0;
        for (int p = 0; p < 8; p++) begin
            if (sh_mode[p]) begin
                eff[2*p] = sh_act[2*p];
                hit[2*p] = sh_act[2*p] && (((v ^ sh_cfg[2*p][5:0]) & sh_cfg[2*p+1][5:0]) == 6'd0);
            end else begin
                eff[2*p]   = sh_act[2*p];
                eff[2*p+1] = sh_act[2*p+1];
                hit[2*p]   = sh_act[2*p]   && (v == sh_cfg[2*p][5:0]);
                hit[2*p+1] = sh_act[2*p+1] && (v == sh_cfg[2*p+1][5:0]);
            end
        end
        any_rx = 1'b0;
        for (int i = 0; i < 16; i++) if (eff[i] && !sh_cfg[i][6]) any_rx = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (hit[i]) begin
                return {sh_cfg[i][6], !sh_cfg[i][6], 1'b1, 4'(i), sh_cfg[i][9:7], sh_cfg[i][10]};
            end
        end
        return {1'b0, !any_rx, 9'd0};
    endfunction

    task automatic check(input string req, input logic [10:0] act_v, input logic [10:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 5'd16) sh_cfg[a[3:0]] = d[10:0];
        else if (a == 5'd16) sh_act = d;
        else if (a == 5'd17) sh_mode = d[7:0];
    endtask

    // Strobe one identifier, check result and the idle cycle after it.
    task automatic send(input string req, input logic [5:0] v);
        logic [10:0] exp_v;
        exp_v = model(v);
        @(negedge clk);
        id_vld = 1'b1; id = v;
        @(negedge clk);
        id_vld = 1'b0;
        check(req, outs(), exp_v);
        @(negedge clk);
        check("R10", outs(), 11'd0);
    endtask

    function automatic logic [15:0] slot(input logic [5:0] k, input logic tx,
                                         input logic [2:0] len, input logic chk);
        return {5'd0, chk, len, tx, k};
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 16; i++) sh_cfg[i] = '0;
        sh_act = '0; sh_mode = '0;
        repeat (3) @(negedge clk);
        check("R1", outs(), 11'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 11'd0);

        // R2: nothing active
        send("R2", 6'h00); send("R2", 6'h3F); send("R2", 6'h15);

        // R3 / R6: single TX slot
        wr(5'd0, slot(6'h12, 1'b1, 3'd4, 1'b1));
        wr(5'd16, 16'h0001);
        send("R3", 6'h12);
        send("R6", 6'h13);

        // R4 / R7: add an RX slot
        wr(5'd3, slot(6'h20, 1'b0, 3'd7, 1'b0));
        wr(5'd16, 16'h0009);
        send("R4", 6'h20);
        send("R7", 6'h05);

        // R5: pair 2 in mask mode, key 0x00, mask 0x30
        wr(5'd4, slot(6'h00, 1'b1, 3'd2, 1'b0));
        wr(5'd5, slot(6'h30, 1'b0, 3'd1, 1'b1));
        wr(5'd17, 16'h0004);
        wr(5'd16, 16'h0039);
        send("R5", 6'h0F);
        send("R5", 6'h30);
        send("R5", 6'h1A);

        // R9: inactive slot ignored
        wr(5'd6, slot(6'h2A, 1'b1, 3'd0, 1'b0));
        send("R9", 6'h2A);

        // R8: two slots on the same key
        wr(5'd1, slot(6'h12, 1'b0, 3'd5, 1'b0));
        wr(5'd16, 16'h003B);
        send("R8", 6'h12);
        wr(5'd16, 16'h003A);
        send("R8", 6'h12);

        // R11: unmapped write has no effect
        wr(5'd31, 16'hFFFF);
        wr(5'd18, 16'h0000);
        send("R11", 6'h12);
        send("R11", 6'h20);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 3) == 0) begin
                logic [4:0] a;
                a = 5'($urandom % 19);
                wr(a, 16'($urandom));
            end
            if (($urandom % 4) == 0) begin
                logic [3:0] s;
                s = 4'($urandom);
                send("R8", sh_cfg[s][5:0]);
            end else begin
                send("R11", 6'($urandom));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule